// File: doc/BRIEF.md
# GPIO Port with Bit-Banged SMBus

This block is a small general-purpose I/O port that software reaches through a byte-wide register window of four lanes. Lane 0 holds input levels and is read-only. Lane 1 holds output values. Lane 2 holds one direction bit per pin, where 1 selects output. Lane 3 is empty and reads as zero. Pins 0 and 1 are not ordinary pins. They carry the data and clock lines of a two-wire SMBus that software toggles by hand. Both lines are open-drain: the block only ever pulls a line low or releases it to the pull-up. The remaining pins are plain latched outputs with enables, plus synchronised inputs.

A write to lane 1 or lane 2 takes effect only when the new byte differs from the stored one. Such a write starts a refresh of the input lane. The input lane then holds still while the new line drive propagates through the pad register and the synchronisers. After that, the lane is rebuilt from the synchronised inputs. Bit 0 of the rebuilt lane is the clock line when the clock's direction bit is set, and the data line otherwise. This lets firmware read back the wired bus state after every bit-bang step. The attached SMBus devices are outside the block.

Top module: `gpio_smbus_port`

## Requirements
- R1: After a synchronous reset, lanes 0, 1 and 2 read 0x00 (with the general inputs held at zero), both bus pull-down outputs are 0 (lines released), and the output and output-enable buses are 0x00.
- R2: A read strobe at offset N loads acc_rdata with lane N in the following cycle: offset 0 gives the input lane, 1 the output lane, 2 the direction lane, and 3 gives 0x00.
- R3: Writes to offset 0 and offset 3 change no state and start no input refresh.
- R4: A write to offset 1 or 2 is stored and starts an input refresh only if its data differs from the stored byte; a write of equal data does nothing.
- R5: The data pull-down output is 1 exactly when direction bit 0 is 1 and output bit 0 is 0, one cycle after the state changes.
- R6: The clock pull-down output is 1 exactly when direction bit 1 is 1 and output bit 1 is 0; with direction bit 1 cleared the clock line is always released.
- R7: SYNC_STAGES+2 cycles after an accepted write, input bit 0 takes the synchronised clock line level if direction bit 1 is set, else the synchronised data line level; it keeps that value until the next refresh.
- R8: Outside a refresh window, input bits 7..1 follow gp_in[7:1] through the synchronisers; during the window they hold, and they are reloaded when the window closes.
- R9: gp_out equals the output lane, and gp_oe equals the direction lane with bits 0 and 1 forced to 0, one cycle after the state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_wr | input | 1 | Single-byte write strobe |
| acc_rd | input | 1 | Single-byte read strobe |
| acc_addr | input | 2 | Lane offset |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Registered read data |
| gp_in | input | 7 | General-purpose input levels for pins 7..1 (asynchronous) |
| gp_out | output | 8 | Output lane driven to pins |
| gp_oe | output | 8 | Output enables for general pins (bits 0 and 1 always 0) |
| sda_low_o | output | 1 | Pull data line low when 1 |
| scl_low_o | output | 1 | Pull clock line low when 1 |
| sda_line_i | input | 1 | Observed data line level |
| scl_line_i | input | 1 | Observed clock line level |

## Verification
A wrong direction or output bit appears on the pull-down outputs one cycle after the write. It also corrupts the captured bus bit that is read back from lane 0 a few cycles later. A refresh that starts when it should not, or fails to start, shows up as a stale or unexpected bit 0. This shows after the settle window, by which time the bench has pulled the external lines low behind the block's back. A window that ends early or late shows as input bits 7..1 changing while they should be frozen. The bench sweeps every combination of the two bus direction and output bits against every external line-low pattern. It also sweeps all general input values and compares each read against values worked out from the requirements.

// File: rtl/gsb_pkg.sv
package gsb_pkg;
  localparam int LANE_W = 8;
  localparam int SDA_BIT = 0;
  localparam int SCL_BIT = 1;

  typedef enum logic [1:0] {
    LANE_IN   = 2'd0,
    LANE_OUT  = 2'd1,
    LANE_DIR  = 2'd2,
    LANE_NONE = 2'd3
  } lane_e;
endpackage

// File: rtl/gsb_sync.sv
module gsb_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= RST_VAL;
        else     chain[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= RST_VAL;
        else     chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gsb_regs.sv
module gsb_regs
  import gsb_pkg::*;
#(
  parameter int DW     = LANE_W,
  parameter int SETTLE = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic          rd,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:1] gp_sync,
  input  logic          sda_sync,
  input  logic          scl_sync,
  output logic [DW-1:0] in_q,
  output logic [DW-1:0] out_q,
  output logic [DW-1:0] dir_q,
  output logic [DW-1:0] rdata
);
  localparam int CW = $clog2(SETTLE + 1);

  logic          pend;
  logic [CW-1:0] cnt;
  logic [DW-1:0] cur_byte;
  logic [DW-1:0] rd_mux;
  logic          hit_out, hit_dir, accept, capture, bus_bit;

  // byte currently stored at the addressed lane
  always_comb begin
    unique case (lane_e'(addr))
      LANE_IN:   cur_byte = in_q;
      LANE_OUT:  cur_byte = out_q;
      LANE_DIR:  cur_byte = dir_q;
      default:   cur_byte = '0;
    endcase
  end

  assign rd_mux  = cur_byte;
  assign hit_out = wr && (lane_e'(addr) == LANE_OUT);
  assign hit_dir = wr && (lane_e'(addr) == LANE_DIR);
  assign accept  = (hit_out || hit_dir) && (wdata != cur_byte);
  assign capture = pend && (cnt == '0) && !accept;
  assign bus_bit = dir_q[SCL_BIT] ? scl_sync : sda_sync;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
      dir_q <= '0;
      in_q  <= '0;
      pend  <= 1'b0;
      cnt   <= '0;
      rdata <= '0;
    end else begin
      if (accept && hit_out) out_q <= wdata;
      if (accept && hit_dir) dir_q <= wdata;

      if (accept) begin
        pend <= 1'b1;
        cnt  <= CW'(SETTLE);
      end else if (capture) begin
        pend <= 1'b0;
      end else if (pend) begin
        cnt <= cnt - CW'(1);
      end

      if (capture)   in_q <= {gp_sync, bus_bit};
      else if (!pend) in_q[DW-1:1] <= gp_sync;

      if (rd) rdata <= rd_mux;
    end
  end

  // read-only and empty lanes never start a refresh
  assert_ro_lane_R3: assert property (@(posedge clk) disable iff (rst)
    (wr && (addr == 2'd0 || addr == 2'd3) && !pend) |=> !pend);

  assert_ro_lane_state_R3: assert property (@(posedge clk) disable iff (rst)
    (wr && (addr == 2'd0 || addr == 2'd3)) |=> ($stable(out_q) && $stable(dir_q)));

  // equal data leaves the lane alone
  assert_equal_write_R4: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == 2'd1 && wdata == out_q) |=> $stable(out_q));

  // a differing write opens a full-length window
  assert_window_open_R4: assert property (@(posedge clk) disable iff (rst)
    accept |=> (pend && cnt == CW'(SETTLE)));

  // input lane frozen while the window counts down
  assert_window_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (pend && cnt != '0) |=> $stable(in_q));

  // window closes right after capture
  assert_capture_close_R7: assert property (@(posedge clk) disable iff (rst)
    capture |=> (!pend && in_q[0] == $past(bus_bit)));
endmodule

// File: rtl/gsb_pads.sv
module gsb_pads
  import gsb_pkg::*;
#(
  parameter int DW = LANE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] out_q,
  input  logic [DW-1:0] dir_q,
  output logic          sda_low,
  output logic          scl_low,
  output logic [DW-1:0] gp_out,
  output logic [DW-1:0] gp_oe
);
  localparam logic [DW-1:0] BUS_MASK = DW'((1 << SDA_BIT) | (1 << SCL_BIT));

  always_ff @(posedge clk) begin
    if (rst) begin
      sda_low <= 1'b0;
      scl_low <= 1'b0;
      gp_out  <= '0;
      gp_oe   <= '0;
    end else begin
      sda_low <= dir_q[SDA_BIT] & ~out_q[SDA_BIT];
      scl_low <= dir_q[SCL_BIT] & ~out_q[SCL_BIT];
      gp_out  <= out_q;
      gp_oe   <= dir_q & ~BUS_MASK;
    end
  end

  assert_sda_drive_R5: assert property (@(posedge clk) disable iff (rst)
    sda_low |-> ($past(dir_q[SDA_BIT]) && !$past(out_q[SDA_BIT])));

  assert_scl_release_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(dir_q[SCL_BIT]) |-> !scl_low);

  assert_bus_oe_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (gp_oe & BUS_MASK) == '0);
endmodule

// File: rtl/gpio_smbus_port.sv
module gpio_smbus_port
  import gsb_pkg::*;
#(
  parameter int DW          = LANE_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_wr,
  input  logic          acc_rd,
  input  logic [1:0]    acc_addr,
  input  logic [DW-1:0] acc_wdata,
  output logic [DW-1:0] acc_rdata,
  input  logic [DW-1:1] gp_in,
  output logic [DW-1:0] gp_out,
  output logic [DW-1:0] gp_oe,
  output logic          sda_low_o,
  output logic          scl_low_o,
  input  logic          sda_line_i,
  input  logic          scl_line_i
);
  // pad register plus synchroniser depth before a line level is usable
  localparam int SETTLE = SYNC_STAGES + 1;

  logic [DW-1:1] gp_sync;
  logic [1:0]    bus_sync;
  logic [DW-1:0] in_q, out_q, dir_q;

  gsb_sync #(.W(DW-1), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_gp_sync (
    .clk (clk),
    .rst (rst),
    .d   (gp_in),
    .q   (gp_sync)
  );

  gsb_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_bus_sync (
    .clk (clk),
    .rst (rst),
    .d   ({scl_line_i, sda_line_i}),
    .q   (bus_sync)
  );

  gsb_regs #(.DW(DW), .SETTLE(SETTLE)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr       (acc_wr),
    .rd       (acc_rd),
    .addr     (acc_addr),
    .wdata    (acc_wdata),
    .gp_sync  (gp_sync),
    .sda_sync (bus_sync[0]),
    .scl_sync (bus_sync[1]),
    .in_q     (in_q),
    .out_q    (out_q),
    .dir_q    (dir_q),
    .rdata    (acc_rdata)
  );

  gsb_pads #(.DW(DW)) u_pads (
    .clk     (clk),
    .rst     (rst),
    .out_q   (out_q),
    .dir_q   (dir_q),
    .sda_low (sda_low_o),
    .scl_low (scl_low_o),
    .gp_out  (gp_out),
    .gp_oe   (gp_oe)
  );

  assert_out_follow_R9: assert property (@(posedge clk) disable iff (rst)
    gp_out == $past(out_q));
endmodule

// File: tb/gpio_smbus_port_tb.sv
module gpio_smbus_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       acc_wr = 1'b0, acc_rd = 1'b0;
  logic [1:0] acc_addr = '0;
  logic [7:0] acc_wdata = '0;
  logic [7:0] acc_rdata;
  logic [7:1] gp_in = '0;
  logic [7:0] gp_out, gp_oe;
  logic       sda_low_o, scl_low_o;
  logic       ext_sda_low = 1'b0, ext_scl_low = 1'b0;
  logic       sda_line, scl_line;

  int vectors = 0;
  int fails   = 0;
  logic done = 1'b0;

  // wired-AND of block pull-down and external pull-down
  assign sda_line = !(sda_low_o || ext_sda_low);
  assign scl_line = !(scl_low_o || ext_scl_low);

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_smbus_port u_dut (
    .clk        (clk),
    .rst        (rst),
    .acc_wr     (acc_wr),
    .acc_rd     (acc_rd),
    .acc_addr   (acc_addr),
    .acc_wdata  (acc_wdata),
    .acc_rdata  (acc_rdata),
    .gp_in      (gp_in),
    .gp_out     (gp_out),
    .gp_oe      (gp_oe),
    .sda_low_o  (sda_low_o),
    .scl_low_o  (scl_low_o),
    .sda_line_i (sda_line),
    .scl_line_i (scl_line)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    acc_wr = 1'b1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_wr = 1'b0;
  endtask

  task automatic rd_byte(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    acc_rd = 1'b1; acc_addr = a;
    @(negedge clk);
    acc_rd = 1'b0;
    d = acc_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected <%0d cycles", cyc, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    logic [7:0] out_v, dir_v;
    logic       tog;
    logic       last_bit;

    idle(4);
    rst = 1'b0;
    idle(1);

    // R1: reset state
    rd_byte(2'd0, rv); check("R1 in lane", rv, 8'h00);
    rd_byte(2'd1, rv); check("R1 out lane", rv, 8'h00);
    rd_byte(2'd2, rv); check("R1 dir lane", rv, 8'h00);
    check("R1 sda released", {7'd0, sda_low_o}, 8'h00);
    check("R1 scl released", {7'd0, scl_low_o}, 8'h00);
    check("R1 gp_out", gp_out, 8'h00);
    check("R1 gp_oe", gp_oe, 8'h00);

    // R2: lane reads and empty lane
    wr_byte(2'd1, 8'hA5);
    wr_byte(2'd2, 8'h3C);
    idle(8);
    rd_byte(2'd1, rv); check("R2 out lane", rv, 8'hA5);
    rd_byte(2'd2, rv); check("R2 dir lane", rv, 8'h3C);
    rd_byte(2'd3, rv); check("R2 empty lane", rv, 8'h00);
    // R9: pin buses
    check("R9 gp_out", gp_out, 8'hA5);
    check("R9 gp_oe", gp_oe, 8'h3C);

    // establish known bus bit: data line released, clock dir clear
    wr_byte(2'd2, 8'h00);
    wr_byte(2'd1, 8'h01);
    idle(8);
    rd_byte(2'd0, rv); check("R7 released data", rv, 8'h01);
    last_bit = 1'b1;

    // R3: writes to lanes 0 and 3 are ignored, no refresh
    ext_sda_low = 1'b1;
    wr_byte(2'd0, 8'hFE);
    wr_byte(2'd3, 8'h77);
    idle(8);
    rd_byte(2'd0, rv); check("R3 in lane untouched", rv, 8'h01);
    rd_byte(2'd3, rv); check("R3 empty lane", rv, 8'h00);
    rd_byte(2'd1, rv); check("R3 out lane", rv, 8'h01);

    // R4: equal write does not refresh; differing one does
    wr_byte(2'd1, 8'h01);
    idle(8);
    rd_byte(2'd0, rv); check("R4 equal write", rv, 8'h01);
    wr_byte(2'd1, 8'h05);
    idle(8);
    rd_byte(2'd0, rv); check("R4 differing write", rv, 8'h00);
    rd_byte(2'd1, rv); check("R4 stored", rv, 8'h05);
    ext_sda_low = 1'b0;

    // R5 R6 R7 R9: exhaustive sweep of bus dir/out bits and external pulls
    tog = 1'b0;
    for (int combo = 0; combo < 16; combo++) begin
      for (int ext = 0; ext < 4; ext++) begin
        logic exp_sda_low, exp_scl_low, exp_sda_line, exp_scl_line, exp_bit;
        dir_v = {6'd0, combo[3:2]};
        tog   = ~tog;
        out_v = {tog, 5'd0, combo[1:0]};
        ext_sda_low = ext[0];
        ext_scl_low = ext[1];
        wr_byte(2'd2, dir_v);
        wr_byte(2'd1, out_v);
        idle(8);
        exp_sda_low  = dir_v[0] && !out_v[0];
        exp_scl_low  = dir_v[1] && !out_v[1];
        exp_sda_line = !(exp_sda_low || ext[0]);
        exp_scl_line = !(exp_scl_low || ext[1]);
        exp_bit      = dir_v[1] ? exp_scl_line : exp_sda_line;
        check("R5 sda pull-down", {7'd0, sda_low_o}, {7'd0, exp_sda_low});
        check("R6 scl pull-down", {7'd0, scl_low_o}, {7'd0, exp_scl_low});
        check("R9 gp_out sweep", gp_out, out_v);
        check("R9 gp_oe sweep", gp_oe, 8'h00);
        rd_byte(2'd0, rv);
        check("R7 captured bus bit", rv, {7'd0, exp_bit});
        last_bit = exp_bit;
      end
    end
    ext_sda_low = 1'b0;
    ext_scl_low = 1'b0;

    // R8: general inputs follow when idle
    for (int v = 0; v < 128; v++) begin
      gp_in = v[6:0];
      idle(5);
      rd_byte(2'd0, rv);
      check("R8 input follow", rv, {v[6:0], last_bit});
    end

    // R8: frozen during refresh, reloaded after
    gp_in = 7'h00;
    idle(6);
    gp_in = 7'h55;
    wr_byte(2'd1, 8'hC3);
    rd_byte(2'd0, rv);
    check("R8 frozen in window", rv, {7'h00, last_bit});
    idle(8);
    // dir 0x03, out 0xC3: both lines released, clock line selected -> 1
    rd_byte(2'd0, rv);
    check("R8 reloaded after window", rv, {7'h55, 1'b1});

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule